// File: doc/BRIEF.md
# Signed-Digit Weighted Shift-Add Accumulator

This block takes eight signed 8-bit operands on one wide input bus and forms the weighted sum Y = Σ Ri·2^i. Operand i moves up i digit positions before it is added. Every partial sum is kept in redundant binary signed-digit form, with two bits per digit, so no addition has a carry chain running across the word. The result is returned in the same signed-digit form. Converting it back to two's complement is left to the consumer.

Internally the eight operands are split into a low half (R0..R3) and a high half (R4..R7). Each half has its own signed-digit accumulator. Over four cycles each accumulator adds one shifted two's-complement operand per cycle, using a signed-digit plus two's-complement adder. A final signed-digit plus signed-digit addition merges the two halves into the result register. A one-cycle `done` pulse marks a fresh result.

Top module: `bsdShiftAcc`

## Requirements
- R1: Each result digit i sits at bits [2i+1:2i] of `result` and has weight 2^i. Code 00 means -1, codes 01 and 10 mean 0, and code 11 means +1.
- R2: Operand i is 8-bit two's complement, read from `opBus[8i+7:8i]`. On completion the decoded `result` equals Σ Ri·2^i, with i running from 0 to 7.
- R3: The result has 17 digits (34 bits). It is exact for every operand combination, including all operands at -128 (value -32640) and all operands at 127 (value 32385).
- R4: When `start` is accepted at a rising edge, `done` is high during the cycle that follows the fifth rising edge after that one. Before then it stays low.
- R5: `done` is a single-cycle pulse.
- R6: `result` changes only at the edge that raises `done`. Between completions it holds its value, even if `opBus` changes.
- R7: Operands are captured at the edge that accepts `start`. A `start` that arrives while a computation is running is ignored, and changes to `opBus` during the computation have no effect on that result.
- R8: A synchronous active-low reset sets every result digit to code 01 (value zero) and drives `done` low.
- R9: The block writes zero digits only with code 01. Code 10 never appears in `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation on the operands currently on `opBus` |
| opBus | input | 64 | Eight packed 8-bit two's-complement operands; operand i at [8i+7:8i] |
| done | output | 1 | One-cycle pulse when a new result is available |
| result | output | 34 | 17-digit signed-digit sum, two bits per digit |

## Verification
The checker assumes that `start` is only acted on when the block is idle, or in the cycle right after `done`. It mirrors that acceptance rule with its own countdown, and it takes the operand bus as valid only at the accepting edge. The stimulus honours both assumptions. The bench raises `start` and then also raises it again in the middle of a computation while scrambling `opBus`, so the ignore path is exercised without going outside what the checker expects. Random operands from a fixed seed are mixed with directed extremes (all -128, all 127, a lone negative top operand, all zero), and every result is decoded and compared against a software weighted sum.

// File: rtl/bsdAccPkg.sv
package bsdAccPkg;

  typedef logic [1:0] bsdDigit_t;

  localparam bsdDigit_t DIG_NEG  = 2'b00;
  localparam bsdDigit_t DIG_ZERO = 2'b01;
  localparam bsdDigit_t DIG_POS  = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic accumEn;
    logic mergeEn;
  } accStrobes_t;

  function automatic logic signed [2:0] digitVal(input bsdDigit_t d);
    case (d)
      2'b00:   return -3'sd1;
      2'b11:   return 3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic bsdDigit_t digitEnc(input logic signed [2:0] v);
    if (v < 3'sd0)      return DIG_NEG;
    else if (v > 3'sd0) return DIG_POS;
    else                return DIG_ZERO;
  endfunction

  // transfer digit of a position, given its digit sum and whether the lower pair is non-negative
  function automatic logic signed [2:0] transferOf(input logic signed [2:0] pSum, input logic lowNonNeg);
    if (pSum >= 3'sd2)       return 3'sd1;
    else if (pSum <= -3'sd2) return -3'sd1;
    else if (pSum == 3'sd1)  return lowNonNeg ? 3'sd1 : 3'sd0;
    else if (pSum == -3'sd1) return lowNonNeg ? 3'sd0 : -3'sd1;
    else                     return 3'sd0;
  endfunction

  // interim digit kept at a position
  function automatic logic signed [2:0] interimOf(input logic signed [2:0] pSum, input logic lowNonNeg);
    if (pSum >= 3'sd2 || pSum <= -3'sd2) return 3'sd0;
    else if (pSum == 3'sd1)  return lowNonNeg ? -3'sd1 : 3'sd1;
    else if (pSum == -3'sd1) return lowNonNeg ? -3'sd1 : 3'sd1;
    else                     return 3'sd0;
  endfunction

endpackage

// File: rtl/bsdAdd.sv
module bsdAdd
  import bsdAccPkg::*;
#(
  parameter int N = 17
) (
  input  logic [2*N-1:0] aVec,
  input  logic [2*N-1:0] bVec,
  output logic [2*N-1:0] sumVec
);

  logic signed [2:0] transfer [N];
  logic signed [2:0] interim  [N];

  assign transfer[0] = 3'sd0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_digit
      logic signed [2:0] pSum;
      logic              lowNonNeg;

      assign pSum = digitVal(aVec[2*i +: 2]) + digitVal(bVec[2*i +: 2]);

      if (i == 0) begin : g_base
        assign lowNonNeg = 1'b1;
      end else begin : g_upper
        assign lowNonNeg = (|aVec[2*i-2 +: 2]) && (|bVec[2*i-2 +: 2]);
      end

      assign interim[i] = interimOf(pSum, lowNonNeg);

      if (i < N - 1) begin : g_xfer
        assign transfer[i+1] = transferOf(pSum, lowNonNeg);
      end

      assign sumVec[2*i +: 2] = digitEnc(interim[i] + transfer[i]);
    end
  endgenerate

endmodule

// File: rtl/bsdAddTc.sv
module bsdAddTc
  import bsdAccPkg::*;
#(
  parameter int N       = 17,
  parameter int W       = 8,
  parameter int SHIFT_W = 3
) (
  input  logic [2*N-1:0]     accVec,
  input  logic [W-1:0]       tcVal,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [2*N-1:0]     sumVec
);

  logic [2*N-1:0] tcDigits;

  // two's-complement bits become digits by their sign; the rest are code 01
  always_comb begin
    for (int j = 0; j < N; j++) begin
      tcDigits[2*j +: 2] = DIG_ZERO;
      for (int b = 0; b < W; b++) begin
        if (j == b + int'(shiftAmt) && tcVal[b]) begin
          tcDigits[2*j +: 2] = (b == W - 1) ? DIG_NEG : DIG_POS;
        end
      end
    end
  end

  bsdAdd #(.N(N)) add_i (
    .aVec  (accVec),
    .bVec  (tcDigits),
    .sumVec(sumVec)
  );

endmodule

// File: rtl/bsdAccCtrl.sv
module bsdAccCtrl
  import bsdAccPkg::*;
#(
  parameter int HALF_OPS = 4,
  localparam int STEP_W  = (HALF_OPS > 1) ? $clog2(HALF_OPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output accStrobes_t       strobes,
  output logic [STEP_W-1:0] step,
  output logic              done
);

  typedef enum logic [1:0] { ST_IDLE, ST_ACCUM, ST_MERGE } ctrlState_t;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(HALF_OPS - 1);

  ctrlState_t state;
  logic [STEP_W-1:0] stepQ;

  always_comb begin
    strobes.load    = (state == ST_IDLE) && start;
    strobes.accumEn = (state == ST_ACCUM);
    strobes.mergeEn = (state == ST_MERGE);
  end

  assign step = stepQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stepQ <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobes.mergeEn;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ACCUM;
          stepQ <= '0;
        end
        ST_ACCUM: begin
          if (stepQ == LAST_STEP) begin
            state <= ST_MERGE;
            stepQ <= '0;
          end else begin
            stepQ <= stepQ + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bsdAccDatapath.sv
module bsdAccDatapath
  import bsdAccPkg::*;
#(
  parameter int NUM_OPS = 8,
  parameter int OP_BITS = 8,
  localparam int HALF_OPS = NUM_OPS / 2,
  localparam int STEP_W   = (HALF_OPS > 1) ? $clog2(HALF_OPS) : 1,
  localparam int SHIFT_W  = $clog2(NUM_OPS),
  localparam int RES_DIG  = OP_BITS + NUM_OPS + 1,
  localparam int RES_W    = 2 * RES_DIG
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  accStrobes_t                strobes,
  input  logic [STEP_W-1:0]          step,
  input  logic [NUM_OPS*OP_BITS-1:0] opBus,
  output logic [RES_W-1:0]           result
);

  localparam logic [RES_W-1:0] ZERO_VEC = {RES_DIG{DIG_ZERO}};

  logic [OP_BITS-1:0] opReg    [NUM_OPS];
  logic [RES_W-1:0]   accHalf  [2];
  logic [RES_W-1:0]   sumHalf  [2];
  logic [SHIFT_W-1:0] shiftAmt [2];
  logic [RES_W-1:0]   mergeSum;

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      assign shiftAmt[h] = SHIFT_W'(h * HALF_OPS) + SHIFT_W'(step);

      bsdAddTc #(.N(RES_DIG), .W(OP_BITS), .SHIFT_W(SHIFT_W)) addTc_i (
        .accVec  (accHalf[h]),
        .tcVal   (opReg[shiftAmt[h]]),
        .shiftAmt(shiftAmt[h]),
        .sumVec  (sumHalf[h])
      );

      always_ff @(posedge clk) begin
        if (!rstN || strobes.load) accHalf[h] <= ZERO_VEC;
        else if (strobes.accumEn)  accHalf[h] <= sumHalf[h];
      end
    end
  endgenerate

  bsdAdd #(.N(RES_DIG)) merge_i (
    .aVec  (accHalf[0]),
    .bVec  (accHalf[1]),
    .sumVec(mergeSum)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_OPS; i++) opReg[i] <= '0;
      result <= ZERO_VEC;
    end else begin
      if (strobes.load) begin
        for (int i = 0; i < NUM_OPS; i++) opReg[i] <= opBus[i*OP_BITS +: OP_BITS];
      end
      if (strobes.mergeEn) result <= mergeSum;
    end
  end

endmodule

// File: rtl/bsdShiftAcc.sv
module bsdShiftAcc
  import bsdAccPkg::*;
#(
  parameter int NUM_OPS = 8,
  parameter int OP_BITS = 8,
  localparam int HALF_OPS = NUM_OPS / 2,
  localparam int STEP_W   = (HALF_OPS > 1) ? $clog2(HALF_OPS) : 1,
  localparam int RES_W    = 2 * (OP_BITS + NUM_OPS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [NUM_OPS*OP_BITS-1:0] opBus,
  output logic                       done,
  output logic [RES_W-1:0]           result
);

  accStrobes_t       strobes;
  logic [STEP_W-1:0] step;

  bsdAccCtrl #(.HALF_OPS(HALF_OPS)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .step   (step),
    .done   (done)
  );

  bsdAccDatapath #(.NUM_OPS(NUM_OPS), .OP_BITS(OP_BITS)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .step   (step),
    .opBus  (opBus),
    .result (result)
  );

endmodule

// File: rtl/bsdShiftAccChk.sv
module bsdShiftAccChk #(
  parameter int NUM_OPS = 8,
  parameter int OP_BITS = 8,
  localparam int RES_DIG = OP_BITS + NUM_OPS + 1,
  localparam int RES_W   = 2 * RES_DIG
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic [NUM_OPS*OP_BITS-1:0] opBus,
  input logic                       done,
  input logic [RES_W-1:0]           result
);

  logic [2:0]                 chkCnt;
  logic [NUM_OPS*OP_BITS-1:0] capOps;

  function automatic int decodeVec(input logic [RES_W-1:0] v);
    int acc = 0;
    for (int i = 0; i < RES_DIG; i++) begin
      if (v[2*i +: 2] == 2'b11)      acc += (1 << i);
      else if (v[2*i +: 2] == 2'b00) acc -= (1 << i);
    end
    return acc;
  endfunction

  function automatic int weighted(input logic [NUM_OPS*OP_BITS-1:0] ops);
    int acc = 0;
    for (int i = 0; i < NUM_OPS; i++) begin
      acc += int'($signed(ops[i*OP_BITS +: OP_BITS])) * (1 << i);
    end
    return acc;
  endfunction

  function automatic int altZeros(input logic [RES_W-1:0] v);
    int n = 0;
    for (int i = 0; i < RES_DIG; i++) if (v[2*i +: 2] == 2'b10) n++;
    return n;
  endfunction

  // own model of when a start is taken and when the result must appear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkCnt <= '0;
      capOps <= '0;
    end else if (start && chkCnt <= 3'd1) begin
      chkCnt <= 3'd6;
      capOps <= opBus;
    end else if (chkCnt != 3'd0) begin
      chkCnt <= chkCnt - 3'd1;
    end
  end

  assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    done == (chkCnt == 3'd1));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  assert_result_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> decodeVec(result) == weighted(capOps));

  assert_zero_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> altZeros(result) == 0);

endmodule

bind bsdShiftAcc bsdShiftAccChk #(.NUM_OPS(NUM_OPS), .OP_BITS(OP_BITS)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .opBus (opBus),
  .done  (done),
  .result(result)
);

// File: tb/bsdShiftAcc_tb_top.sv
module bsdShiftAcc_tb_top;

  localparam int NOPS  = 8;
  localparam int OBITS = 8;
  localparam int NDIG  = OBITS + NOPS + 1;
  localparam int RW    = 2 * NDIG;

  logic            clk = 1'b0;
  logic            rstN;
  logic            start;
  logic [NOPS*OBITS-1:0] opBus;
  logic            done;
  logic [RW-1:0]   result;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #10ns clk = ~clk;

  bsdShiftAcc dut_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opBus (opBus),
    .done  (done),
    .result(result)
  );

  function automatic int decodeRes(input logic [RW-1:0] v);
    int acc = 0;
    for (int i = 0; i < NDIG; i++) begin
      if (v[2*i +: 2] == 2'b11)      acc += (1 << i);
      else if (v[2*i +: 2] == 2'b00) acc -= (1 << i);
    end
    return acc;
  endfunction

  function automatic int expectSum(input logic [NOPS*OBITS-1:0] ops);
    int acc = 0;
    for (int i = 0; i < NOPS; i++) acc += int'($signed(ops[i*OBITS +: OBITS])) * (1 << i);
    return acc;
  endfunction

  function automatic int altCount(input logic [RW-1:0] v);
    int n = 0;
    for (int i = 0; i < NDIG; i++) if (v[2*i +: 2] == 2'b10) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one computation; with midStart a second start and scrambled operands arrive mid-run
  task automatic runOne(input logic [NOPS*OBITS-1:0] ops, input bit midStart, input string req);
    int exp = expectSum(ops);
    opBus = ops;
    start = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (k < 6) check(done == 1'b0, "R4 early done", done, 0);
      else       check(done == 1'b1, "R4 done at fifth edge", done, 1);
      if (midStart && k == 2) begin start = 1'b1; opBus = ~ops; end
      if (midStart && k == 3) start = 1'b0;
    end
    check(decodeRes(result) == exp, {req, " R1 R2 value"}, decodeRes(result), exp);
    check(altCount(result) == 0, "R9 code 10 present", altCount(result), 0);
    if (midStart) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check(done == 1'b0, "R7 ignored start produced done", done, 0);
      end
      check(decodeRes(result) == exp, "R7 result disturbed", decodeRes(result), exp);
    end
  endtask

  initial begin
    #4ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NOPS*OBITS-1:0] ops;
    logic [RW-1:0] held;
    void'($urandom(32'd2024));
    rstN  = 1'b0;
    start = 1'b0;
    opBus = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(result == {NDIG{2'b01}}, "R8 reset digits", result, {NDIG{2'b01}});
    check(done == 1'b0, "R8 reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 corner values
    runOne({NOPS{8'h80}}, 1'b0, "R3 all -128");
    runOne({NOPS{8'h7F}}, 1'b0, "R3 all 127");
    runOne({8'h80, {(NOPS-1){8'h7F}}}, 1'b0, "R3 top -128 rest 127");
    runOne({8'h7F, {(NOPS-1){8'h80}}}, 1'b0, "R3 top 127 rest -128");
    runOne('0, 1'b0, "R2 all zero");
    runOne({4{8'hFF, 8'h01}}, 1'b0, "R2 alternating");

    // R7 start ignored while busy
    runOne({$urandom, $urandom}, 1'b1, "R7 base");

    // R6 result holds while operands change without start
    held = result;
    for (int k = 0; k < 4; k++) begin
      opBus = {$urandom, $urandom};
      @(negedge clk);
      check(done == 1'b0, "R6 spurious done", done, 0);
    end
    check(result == held, "R6 result changed", decodeRes(result), decodeRes(held));

    // random operands, some back to back
    for (int n = 0; n < 40; n++) begin
      ops = {$urandom, $urandom};
      runOne(ops, (n % 10) == 3, "R2 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule